// File: doc/BRIEF.md
# Don't-Care Fill Unit for Scan Pattern Streams

This block sits in a scan-pattern delivery path and turns a stream of partly specified test bits into fully specified bits. Each incoming beat carries a bit value and a flag saying whether that bit matters to the test. Bits that matter go out untouched. Every other bit is replaced by a value that depends on the fill policy in force for the current pattern.

Four policies are offered: constant low, constant high, pseudorandom, and repeat-last-specified. The last policy keeps the shifted stream as flat as possible, so fewer scan cells toggle during shift. That makes it the usual choice when shift power is the limit. The pseudorandom policy trades that power for extra chance fault detection.

The policy is picked at the first beat of each pattern, which is marked with a start strobe. Beats enter and leave through valid/ready handshakes, and every output beat is registered.

Top module: `dcfill_unit`

## Requirements
- R1: While reset is applied and in the cycles after its release, `out_valid` is 0. With `out_ready` at 1, `in_ready` is 1.
- R2: A beat whose `in_care` is 1 leaves with `out_bit` equal to its `in_bit`, whatever the policy.
- R3: Policy code 2'b00 fills each don't-care beat with 0.
- R4: Policy code 2'b01 fills each don't-care beat with 1.
- R5: Policy code 2'b10 fills each don't-care beat with the value of the most recent care beat in the same pattern. Don't-care beats before the first care beat of a pattern get 0. For example, 0XXX1XX leaves as 0000111.
- R6: Policy code 2'b11 fills each don't-care beat from a 16-bit shift register with the following behaviour:
  - The register is loaded with 16'hACE1 at reset.
  - Each such beat takes bit 15 of the register.
  - After that, the register shifts left one place, and the new bit 0 is bit15^bit13^bit12^bit10.
  - No other beat moves the register, and it keeps its state across patterns.
- R7: `mode_sel` is sampled only on an accepted beat with `in_sop` at 1. That beat and the rest of its pattern use the sampled code. Changes to `mode_sel` on other beats have no effect.
- R8: A beat is accepted when `in_valid` and `in_ready` are both 1, and its filled bit appears on the next cycle with `out_valid` at 1. `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, `out_bit` holds still. Beats leave one for one and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_bit | input | 1 | Pattern bit value |
| in_care | input | 1 | 1 when the bit is specified, 0 when it is don't-care |
| in_sop | input | 1 | Marks the first beat of a pattern |
| mode_sel | input | 2 | Fill policy code, sampled on the start beat |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_bit | output | 1 | Filled pattern bit |

## Verification
The embedded properties watch the following on every cycle:
- care values passing through;
- constant fills;
- the adjacent hold clearing at a pattern start;
- the policy register holding between starts;
- the random register never reaching zero and moving only on random fills;
- output stability under backpressure.

Only the directed scenarios can show the following:
- the full adjacent sequence 0XXX1XX mapping to 0000111;
- the exact pseudorandom bit sequence across pattern boundaries;
- a mid-pattern policy change being ignored;
- a beat queued during a stall being taken on the release edge.

// File: rtl/dcfill_pkg.sv
package dcfill_pkg;
  typedef enum logic [1:0] {
    FILL_ZERO = 2'b00,
    FILL_ONE  = 2'b01,
    FILL_ADJ  = 2'b10,
    FILL_RAND = 2'b11
  } fill_mode_e;
endpackage

// File: rtl/dcfill_rst_sync.sv
module dcfill_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dcfill_lfsr.sv
module dcfill_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic rnd_bit
);
  logic [W-1:0] state_q, state_d, tap_bits;
  logic         fb;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_tap
      assign tap_bits[gi] = TAPS[gi] & state_q[gi];
    end
  endgenerate

  assign fb = ^tap_bits;

  always_comb begin
    state_d = state_q;
    if (step) state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign rnd_bit = state_q[W-1];

  // R6: a maximal-length register never falls into the all-zero lock state
  p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R6: the register moves only when a random fill consumes a bit
  p_lfsr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state_q));
endmodule

// File: rtl/dcfill_mode_ctl.sv
module dcfill_mode_ctl
  import dcfill_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       sop,
  input  logic       care,
  input  logic       data,
  input  logic [1:0] mode_sel,
  output fill_mode_e eff_mode,
  output logic       hold_val
);
  fill_mode_e mode_q, mode_d;
  logic       hold_q, hold_d;

  assign eff_mode = sop ? fill_mode_e'(mode_sel) : mode_q;
  assign hold_val = sop ? 1'b0 : hold_q;

  always_comb begin
    mode_d = mode_q;
    hold_d = hold_q;
    if (fire) begin
      mode_d = eff_mode;
      hold_d = care ? data : hold_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= FILL_ZERO;
      hold_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      hold_q <= hold_d;
    end
  end

  // R7: the policy only changes on an accepted pattern-start beat
  p_mode_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && sop) |=> $stable(mode_q));

  // R5: a don't-care pattern start leaves the adjacent hold at 0
  p_hold_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sop && !care) |=> (hold_q == 1'b0));
endmodule

// File: rtl/dcfill_outreg.sv
module dcfill_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_value,
  output logic in_ready,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit
);
  logic vld_q, vld_d, bit_q, bit_d, take;

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    vld_d = vld_q;
    bit_d = bit_q;
    if (take) begin
      vld_d = 1'b1;
      bit_d = in_value;
    end else if (out_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      bit_q <= bit_d;
    end
  end

  assign out_valid = vld_q;
  assign out_bit   = bit_q;

  // R8: a stalled output beat stays put
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R8: an accepted beat is presented on the next cycle
  p_accept_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/dcfill_unit.sv
module dcfill_unit
  import dcfill_pkg::*;
#(
  parameter int          RND_W     = 16,
  parameter logic [RND_W-1:0] RND_TAPS = 16'hB400,
  parameter logic [RND_W-1:0] RND_SEED = 16'hACE1,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  input  logic       in_care,
  input  logic       in_sop,
  input  logic [1:0] mode_sel,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_bit
);
  logic       rst_ni;
  logic       fire, rnd_step, rnd_bit, hold_val, fill_val;
  fill_mode_e eff_mode;

  dcfill_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni)
  );

  assign fire     = in_valid && in_ready;
  assign rnd_step = fire && !in_care && (eff_mode == FILL_RAND);

  dcfill_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_ni), .fire(fire), .sop(in_sop), .care(in_care),
    .data(in_bit), .mode_sel(mode_sel), .eff_mode(eff_mode), .hold_val(hold_val)
  );

  dcfill_lfsr #(.W(RND_W), .TAPS(RND_TAPS), .SEED(RND_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_ni), .step(rnd_step), .rnd_bit(rnd_bit)
  );

  always_comb begin
    if (in_care) fill_val = in_bit;
    else begin
      case (eff_mode)
        FILL_ZERO: fill_val = 1'b0;
        FILL_ONE:  fill_val = 1'b1;
        FILL_ADJ:  fill_val = hold_val;
        default:   fill_val = rnd_bit;
      endcase
    end
  end

  dcfill_outreg u_out (
    .clk(clk), .rst_n(rst_ni), .in_valid(in_valid), .in_value(fill_val),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit)
  );

  // R2: specified bits cross unchanged
  p_care_pass_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (fire && in_care) |=> (out_bit == $past(in_bit)));

  // R3: zero policy yields 0 for unspecified bits
  p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (fire && !in_care && eff_mode == FILL_ZERO) |=> !out_bit);

  // R4: one policy yields 1 for unspecified bits
  p_one_fill_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (fire && !in_care && eff_mode == FILL_ONE) |=> out_bit);
endmodule

// File: tb/tb_dcfill_unit.sv
module tb_dcfill_unit;
  logic       clk, rst_n;
  logic       in_valid, in_ready, in_bit, in_care, in_sop;
  logic [1:0] mode_sel;
  logic       out_valid, out_ready, out_bit;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [1:0]  mode_m;
  logic        hold_m;
  logic [15:0] lfsr_m;

  dcfill_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_care(in_care), .in_sop(in_sop), .mode_sel(mode_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Reference fill model, built from the requirement text
  task automatic model(input logic b, input logic c, input logic s,
                       input logic [1:0] m, output logic e);
    if (s) begin
      mode_m = m;
      hold_m = 1'b0;
    end
    if (c) begin
      e = b;
      hold_m = b;
    end else begin
      case (mode_m)
        2'b00: e = 1'b0;
        2'b01: e = 1'b1;
        2'b10: e = hold_m;
        default: begin
          e = lfsr_m[15];
          lfsr_m = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
        end
      endcase
    end
  endtask

  task automatic send(input logic b, input logic c, input logic s,
                      input logic [1:0] m, input string tag, output logic got);
    logic e;
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; in_care = c; in_sop = s; mode_sel = m;
    chk("R8", "in_ready before beat", in_ready, 1'b1);
    model(b, c, s, m, e);
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, "out_valid", out_valid, 1'b1);
    chk(tag, "out_bit", out_bit, e);
    got = out_bit;
  endtask

  task automatic t_reset();
    chk("R1", "out_valid in reset", out_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid after reset", out_valid, 1'b0);
    chk("R1", "in_ready after reset", in_ready, 1'b1);
  endtask

  task automatic t_const();
    logic g;
    send(1'b1, 1'b0, 1'b1, 2'b00, "R3", g);
    send(1'b1, 1'b1, 1'b0, 2'b00, "R2", g);
    send(1'b1, 1'b0, 1'b0, 2'b00, "R3", g);
    send(1'b0, 1'b0, 1'b1, 2'b01, "R4", g);
    send(1'b0, 1'b1, 1'b0, 2'b01, "R2", g);
    send(1'b0, 1'b0, 1'b0, 2'b01, "R4", g);
  endtask

  task automatic t_adjacent();
    logic [6:0] seq;
    logic       g;
    send(1'b0, 1'b1, 1'b1, 2'b10, "R5", g); seq[6] = g;
    send(1'b1, 1'b0, 1'b0, 2'b10, "R5", g); seq[5] = g;
    send(1'b1, 1'b0, 1'b0, 2'b10, "R5", g); seq[4] = g;
    send(1'b1, 1'b0, 1'b0, 2'b10, "R5", g); seq[3] = g;
    send(1'b1, 1'b1, 1'b0, 2'b10, "R5", g); seq[2] = g;
    send(1'b0, 1'b0, 1'b0, 2'b10, "R5", g); seq[1] = g;
    send(1'b0, 1'b0, 1'b0, 2'b10, "R5", g); seq[0] = g;
    total++;
    if (seq !== 7'b0000111) begin
      bad++;
      $display("FAIL R5 sequence: actual=%b expected=%b", seq, 7'b0000111);
    end
    // new pattern: leading don't-cares return to 0 despite previous hold of 1
    send(1'b1, 1'b0, 1'b1, 2'b10, "R5", g);
    chk("R5", "leading fill", g, 1'b0);
    send(1'b1, 1'b0, 1'b0, 2'b10, "R5", g);
  endtask

  task automatic t_random();
    logic g;
    send(1'b0, 1'b0, 1'b1, 2'b11, "R6", g);
    for (int i = 0; i < 20; i++) begin
      send(i[0], (i % 3) == 0, 1'b0, 2'b11, "R6", g);
    end
    // detour through another policy, register must keep its state
    send(1'b0, 1'b0, 1'b1, 2'b00, "R6", g);
    send(1'b0, 1'b0, 1'b1, 2'b11, "R6", g);
    for (int i = 0; i < 10; i++) begin
      send(1'b0, 1'b0, 1'b0, 2'b11, "R6", g);
    end
  endtask

  task automatic t_mode_ignore();
    logic g;
    send(1'b0, 1'b0, 1'b1, 2'b01, "R7", g);
    send(1'b0, 1'b0, 1'b0, 2'b00, "R7", g);
    chk("R7", "mid-pattern change ignored", g, 1'b1);
    send(1'b1, 1'b0, 1'b0, 2'b10, "R7", g);
    chk("R7", "mid-pattern change ignored", g, 1'b1);
    send(1'b1, 1'b0, 1'b1, 2'b00, "R7", g);
    chk("R7", "new start takes new code", g, 1'b0);
  endtask

  task automatic t_backpressure();
    logic e;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_bit = 1'b1; in_care = 1'b1; in_sop = 1'b0; mode_sel = 2'b00;
    model(1'b1, 1'b1, 1'b0, 2'b00, e);
    @(negedge clk);
    chk("R8", "out_valid", out_valid, 1'b1);
    chk("R8", "out_bit", out_bit, e);
    in_bit = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8", "stalled valid", out_valid, 1'b1);
      chk("R8", "stalled bit", out_bit, 1'b1);
      chk("R8", "stalled in_ready", in_ready, 1'b0);
    end
    out_ready = 1'b1;
    model(1'b0, 1'b1, 1'b0, 2'b00, e);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "queued beat valid", out_valid, 1'b1);
    chk("R8", "queued beat bit", out_bit, e);
    @(negedge clk);
    chk("R8", "drained", out_valid, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; in_care = 1'b0;
    in_sop = 1'b0; mode_sel = 2'b00; out_ready = 1'b1;
    mode_m = 2'b00; hold_m = 1'b0; lfsr_m = 16'hACE1;
    repeat (3) @(negedge clk);
    t_reset();
    t_const();
    t_adjacent();
    t_random();
    t_mode_ignore();
    t_backpressure();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule